// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words by 16 bits. The host presents one access at a time: a request with a direction flag, a word address, write data and a per-byte lane mask. The controller answers with a single done pulse and, for reads, the captured word. On the memory side it drives active-low chip select, write strobe, output enable and one active-low enable per byte lane. It also drives the address bus and a shared 16-bit data bus that it drives only while it is writing.

Every phase length is fixed at elaboration from the memory's nanosecond limits and the clock period, each rounded up to whole cycles. A write holds all its strobes low together for the write pulse and releases them together. It then keeps address and data for one extra cycle. A read first selects the chip with its own bus drivers released, then opens the output and lane enables for the access phase and captures the bus on its final cycle. A mask with no lanes set completes at once and touches no memory pin.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after synchronous reset, chip select, write strobe, output enable and both lane enables are high, `ready` is 1 and `done` is 0.
- R2: A write with a non-empty mask holds chip select, write strobe and the selected lane enables low together for exactly WR_CYC cycles, where WR_CYC is the largest of ceil(address-to-write-end / clock), ceil(select-to-write-end / clock) and ceil(data-setup / clock). The address stays steady while chip select is low. `done` rises WR_CYC+1 cycles after the accepting edge. This gives 3 cycles and 2 select cycles with the default parameters.
- R3: Mask bit 0 controls lane enable 0 and data bits 7..0. Mask bit 1 controls lane enable 1 and data bits 15..8. A masked write leaves the other lane of that word unchanged.
- R4: A read with a non-empty mask spends one cycle with chip select low and output enable high, then RD_CYC cycles with output enable and the selected lane enables low. RD_CYC is the largest of ceil(access time / clock), ceil(output-enable-to-data / clock) and ceil(lane-enable-to-data / clock). `done` rises RD_CYC+1 cycles after the accepting edge, holding the word last stored at that address.
- R5: In `rd_data`, a lane whose mask bit is 0 reads as zero.
- R6: A request with mask 00 raises `done` on the cycle after acceptance, and chip select never goes low for it.
- R7: The controller drives the data bus only during the write pulse and the hold cycle after it, never while output enable is low.
- R8: Write strobe and output enable are never low together, and no phase is shorter than one cycle.
- R9: A request made while `ready` is 0 is ignored. It starts no access and changes no stored data.
- R10: `done` is high only for one cycle per accepted request, and only while `ready` is 1 and chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, taken when `ready` is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address |
| wr_data | input | 16 | Data to write |
| be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| ready | output | 1 | Controller idle, may take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read word, disabled lanes zero |
| mem_addr | output | 16 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |

## Verification
On every cycle the assertions check the pin-level relations between the strobes. The write strobe only appears with chip select and never with output enable. The bus drivers are off whenever output enable is low. The address holds while the chip is selected, and `done` appears only while the memory is deselected. Whether each phase is long enough for the memory, and whether masked lanes really merge and read back correctly, shows only in the bench scenarios. There, a timed memory model returns garbage before its access time expires and flags short write pulses, and a scoreboard compares every lane after sweeps over addresses and all four masks.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM lane controller.
package sram_lane_pkg;

    // Controller phases; every non-idle state holds chip select low except WR_HOLD.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_PULSE  = 3'd1,
        ST_WR_HOLD   = 3'd2,
        ST_RD_TURN   = 3'd3,
        ST_RD_ACCESS = 3'd4
    } ctl_state_t;

    // Whole cycles covering t_ps at a clock of clk_ps, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Largest of three counts.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one controller phase.
// Assumes: load is pulsed on the edge that enters a timed phase with len >= 1;
// last is high on the final cycle of that phase.
module sram_phase_timer #(
    parameter int unsigned MAX_CYC = 4,
    localparam int unsigned W      = $clog2(MAX_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load len-1 on entry, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < W'(MAX_CYC)); // R8
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0)); // R8

endmodule

// File: rtl/sram_lane_io.sv
`timescale 1ns/1ps
// Per-lane data bus driver and read capture register.
// Assumes: drive_en and capture are never high together; a lane whose
// enable is low is captured as zero.
module sram_lane_io #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en,
    input  logic [DW-1:0]    wdata,
    input  logic             capture,
    input  logic [LANES-1:0] lane_en,
    output logic [DW-1:0]    rdata,
    inout  wire  [DW-1:0]    dq
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Drive this lane's slice of the bus only during write phases.
        assign dq[l*LANE_W +: LANE_W] = drive_en ? wdata[l*LANE_W +: LANE_W]
                                                 : {LANE_W{1'bz}};

        // Capture the bus slice at the end of a read, zero for a disabled lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[l*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[l*LANE_W +: LANE_W] <= lane_en[l] ? dq[l*LANE_W +: LANE_W]
                                                        : '0;
        end
    end

    AST_CAPTURE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !drive_en); // R7

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
// Controller for an external asynchronous SRAM with independent byte lanes.
// One access at a time: write = pulse (WR_CYC) + hold (1); read = turn (1)
// + access (RD_CYC); an empty lane mask completes without touching the pins.
// Assumes: the *_PS limits are those of the attached part and CLK_PS is the
// real clock period; memory pins are decoded straight from the state register.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LANES     = 2,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned T_AA_PS   = 10000,
    parameter int unsigned T_DOE_PS  = 5000,
    parameter int unsigned T_DBE_PS  = 5000,
    parameter int unsigned T_AW_PS   = 7000,
    parameter int unsigned T_SCE_PS  = 8000,
    parameter int unsigned T_SD_PS   = 5000,
    localparam int unsigned DW       = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [LANES-1:0]  be,
    output logic              ready,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DW-1:0]     mem_dq,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n
);
    localparam int unsigned WR_CYC  = max3(ps_to_cycles(T_AW_PS, CLK_PS),
                                           ps_to_cycles(T_SCE_PS, CLK_PS),
                                           ps_to_cycles(T_SD_PS, CLK_PS));
    localparam int unsigned RD_CYC  = max3(ps_to_cycles(T_AA_PS, CLK_PS),
                                           ps_to_cycles(T_DOE_PS, CLK_PS),
                                           ps_to_cycles(T_DBE_PS, CLK_PS));
    localparam int unsigned TMR_MAX = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    ctl_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              done_q;
    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_len;
    logic              tmr_last;
    logic              drive_en;
    logic              capture;
    logic              lanes_on;

    assign accept = req && (state == ST_IDLE);

    // Timer load: write pulse length on a write accept, access length from turn.
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(WR_CYC);
        if (accept && wr && (be != '0)) begin
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(WR_CYC);
        end else if (state == ST_RD_TURN) begin
            tmr_load = 1'b1;
            tmr_len  = TMR_W'(RD_CYC);
        end
    end

    sram_phase_timer #(.MAX_CYC(TMR_MAX)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    // Phase sequencing, request latching and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        addr_q  <= addr;
                        wdata_q <= wr_data;
                        mask_q  <= be;
                        if (be == '0)
                            done_q <= 1'b1;
                        else if (wr)
                            state <= ST_WR_PULSE;
                        else
                            state <= ST_RD_TURN;
                    end
                end
                ST_WR_PULSE: begin
                    if (tmr_last) state <= ST_WR_HOLD;
                end
                ST_WR_HOLD: begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                ST_RD_TURN: begin
                    state <= ST_RD_ACCESS;
                end
                ST_RD_ACCESS: begin
                    if (tmr_last) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory pin decode from the registered phase.
    always_comb begin
        mem_ce_n = !((state == ST_WR_PULSE) || (state == ST_RD_TURN) ||
                     (state == ST_RD_ACCESS));
        mem_we_n = (state != ST_WR_PULSE);
        mem_oe_n = (state != ST_RD_ACCESS);
        lanes_on = (state == ST_WR_PULSE) || (state == ST_RD_ACCESS);
        mem_be_n = ~(mask_q & {LANES{lanes_on}});
        drive_en = (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
        capture  = (state == ST_RD_ACCESS) && tmr_last;
    end

    sram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive_en(drive_en),
        .wdata   (wdata_q),
        .capture (capture),
        .lane_en (mask_q),
        .rdata   (rd_data),
        .dq      (mem_dq)
    );

    assign mem_addr = addr_q;
    assign ready    = (state == ST_IDLE);
    assign done     = done_q;

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2
    AST_LANE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be_n != {LANES{1'b1}}) |-> !mem_ce_n); // R3
    AST_NO_DRIVE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> mem_oe_n); // R7
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R8
    AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && (be == '0)) |=> (done && mem_ce_n)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && mem_ce_n)); // R10

endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
// Bench: timed behavioural SRAM model plus scoreboard sweeps over addresses and masks.
module tb_sram_lane_ctrl;
    localparam int CLK_PS = 5000, T_AA = 10000, T_DOE = 5000, T_DBE = 5000;
    localparam int T_AW = 7000, T_SCE = 8000, T_SD = 5000;
    localparam int NADDR = 34;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction
    localparam int WRC = mx(cyc(T_AW), cyc(T_SCE), cyc(T_SD));
    localparam int RDC = mx(cyc(T_AA), cyc(T_DOE), cyc(T_DBE));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [15:0] addr = '0, wr_data = '0;
    logic [1:0] be = '0;
    logic ready, done;
    logic [15:0] rd_data, mem_addr;
    wire  [15:0] mem_dq;
    logic mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0] mem_be_n;

    always #2.5 clk = ~clk;

    sram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wr_data(wr_data), .be(be), .ready(ready), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n)
    );

    int tests = 0, fails = 0, m_chk = 0, m_viol = 0;

    // ---------------- memory model ----------------
    logic [15:0] m_arr [0:255];
    logic [7:0]  m_tag [0:255];
    logic        wact_q = 1'b0;
    logic [15:0] waddr = '0, wlast = '0;
    logic [1:0]  wbe = 2'b11;
    int wrun = 0, drun = 0, rrun = 0, orun = 0;
    logic [15:0] last_a = '0;
    logic rd_act, rd_ok, w_act;

    assign w_act  = !mem_ce_n && !mem_we_n && (mem_be_n != 2'b11);
    assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign rd_ok  = ((rrun + 1) * CLK_PS >= T_AA) && ((orun + 1) * CLK_PS >= T_DOE)
                    && ((orun + 1) * CLK_PS >= T_DBE);
    assign mem_dq[7:0]  = (rd_act && !mem_be_n[0]) ?
                          (rd_ok ? m_arr[mem_addr[7:0]][7:0] : 8'hA5) : 8'hzz;
    assign mem_dq[15:8] = (rd_act && !mem_be_n[1]) ?
                          (rd_ok ? m_arr[mem_addr[7:0]][15:8] : 8'h5A) : 8'hzz;

    // Model timing bookkeeping, write commit and violation reports.
    always @(posedge clk) begin
        if (!rst_n) begin
            wact_q <= 1'b0; wrun <= 0; drun <= 0; rrun <= 0; orun <= 0;
        end else begin
            if (w_act) begin
                if (!wact_q) begin
                    waddr <= mem_addr; wrun <= 1; drun <= 1;
                end else begin
                    wrun <= wrun + 1;
                    drun <= (mem_dq != wlast) ? 1 : drun + 1;
                    if (mem_addr != waddr) begin
                        m_viol++;
                        $display("FAIL R2 address moved in write: %h expected %h", mem_addr, waddr);
                    end
                end
                wlast <= mem_dq;
                wbe   <= mem_be_n;
            end
            if (!w_act && wact_q) begin
                m_chk++;
                if (wrun * CLK_PS < T_AW || wrun * CLK_PS < T_SCE || drun * CLK_PS < T_SD) begin
                    m_viol++;
                    $display("FAIL R2 write pulse %0d ps / data %0d ps, expected >= %0d / %0d",
                             wrun * CLK_PS, drun * CLK_PS, mx(T_AW, T_SCE, 0), T_SD);
                end
                if (!wbe[0]) m_arr[waddr[7:0]][7:0]  <= wlast[7:0];
                if (!wbe[1]) m_arr[waddr[7:0]][15:8] <= wlast[15:8];
                m_tag[waddr[7:0]] <= waddr[15:8];
            end
            wact_q <= w_act;
            if (rd_act && m_tag[mem_addr[7:0]] != mem_addr[15:8]) begin
                m_viol++;
                $display("FAIL R4 read of unwritten address %h, stored tag %h",
                         mem_addr, m_tag[mem_addr[7:0]]);
            end
            if (!mem_ce_n) rrun <= (mem_addr == last_a) ? rrun + 1 : 1;
            else           rrun <= 0;
            orun   <= rd_act ? orun + 1 : 0;
            last_a <= mem_addr;
        end
    end

    // ---------------- bench helpers ----------------
    logic [15:0] sb [0:255];

    function automatic logic [15:0] addr_of(input int i);
        if (i == 32) return 16'hFFFE;
        if (i == 33) return 16'h01FF;
        return {8'h40 + 8'(i), 8'(i)};
    endfunction
    function automatic logic [15:0] data_of(input int i, input int k);
        return {1'b1, 2'(k), 5'(i), 2'(k), 1'b0, 5'(i)};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic run_op(input bit w, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m, output int lat, output int ce_cyc,
                          output logic [15:0] rd);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wr_data = d; be = m;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0; ce_cyc = 0;
        while (!done && lat < 64) begin
            if (!mem_ce_n) ce_cyc++;
            @(negedge clk);
            lat++;
        end
        rd = rd_data;
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        int lat, cec, dn;
        logic [15:0] rd, exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready && !done, "R1 ready/done in reset", {ready, done}, 2'b10);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1 strobes in reset",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, ready, done} == 7'b1111110,
              "R1 idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, ready, done},
              7'b1111110);

        // R2 R8: full-word writes, latency and select length
        for (int i = 0; i < NADDR; i++) begin
            run_op(1'b1, addr_of(i), data_of(i, 0), 2'b11, lat, cec, rd);
            sb[addr_of(i)[7:0]] = data_of(i, 0);
            check(lat == WRC + 1, "R2 write latency", lat, WRC + 1);
            check(cec == WRC, "R8 write select cycles", cec, WRC);
        end
        // R4: full-word reads
        for (int i = 0; i < NADDR; i++) begin
            run_op(1'b0, addr_of(i), 16'h0, 2'b11, lat, cec, rd);
            check(lat == RDC + 1, "R4 read latency", lat, RDC + 1);
            check(cec == RDC + 1, "R4 read select cycles", cec, RDC + 1);
            check(rd == sb[addr_of(i)[7:0]], "R4 read data", rd, sb[addr_of(i)[7:0]]);
        end
        // R3 R6: masked writes over all four masks
        for (int i = 0; i < NADDR; i++) begin
            logic [1:0] m = 2'(i);
            run_op(1'b1, addr_of(i), data_of(i, 1), m, lat, cec, rd);
            exp = (sb[addr_of(i)[7:0]] & ~lane_mask(m)) | (data_of(i, 1) & lane_mask(m));
            sb[addr_of(i)[7:0]] = exp;
            if (m == 2'b00) begin
                check(lat == 0, "R6 empty-mask latency", lat, 0);
                check(cec == 0, "R6 empty-mask select", cec, 0);
            end else begin
                check(lat == WRC + 1, "R3 masked write latency", lat, WRC + 1);
            end
        end
        // R3 R5 R6: masked reads
        for (int i = 0; i < NADDR; i++) begin
            logic [1:0] m = 2'(i + 1);
            run_op(1'b0, addr_of(i), 16'h0, m, lat, cec, rd);
            if (m == 2'b00) begin
                check(lat == 0 && cec == 0, "R6 empty-mask read", {lat[15:0], cec[15:0]}, 0);
            end else begin
                exp = sb[addr_of(i)[7:0]] & lane_mask(m);
                check(rd == exp, "R5 masked read data", rd, exp);
            end
        end
        // R3: full read back of merged words
        for (int i = 0; i < NADDR; i++) begin
            run_op(1'b0, addr_of(i), 16'h0, 2'b11, lat, cec, rd);
            check(rd == sb[addr_of(i)[7:0]], "R3 merged word", rd, sb[addr_of(i)[7:0]]);
        end

        // R9 R10: request held while busy is ignored, one done per access
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = addr_of(0); wr_data = data_of(0, 2); be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        addr = addr_of(1); wr_data = 16'h1234;
        check(!ready, "R9 busy after accept", ready, 0);
        @(negedge clk);
        req = 1'b0;
        dn = 0;
        for (int c = 0; c < 8; c++) begin
            if (done) dn++;
            @(negedge clk);
        end
        sb[addr_of(0)[7:0]] = data_of(0, 2);
        check(dn == 1, "R10 done pulses per access", dn, 1);
        run_op(1'b0, addr_of(1), 16'h0, 2'b11, lat, cec, rd);
        check(rd == sb[addr_of(1)[7:0]], "R9 ignored request left data", rd, sb[addr_of(1)[7:0]]);
        run_op(1'b0, addr_of(0), 16'h0, 2'b11, lat, cec, rd);
        check(rd == data_of(0, 2), "R9 accepted write landed", rd, data_of(0, 2));

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests + m_chk, fails + m_viol);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests + m_chk + 1, fails + m_viol);
        $finish;
    end
endmodule